// File: doc/BRIEF.md
# Programmable Edge/Level Interrupt Controller

The block gathers external interrupt lines into banks of 32 and drives one interrupt request per bank toward the processor. Each source is set up on its own through a small word-addressed register bus. It can be level or edge sensitive, it can treat high/rising or low/falling as active, and it can be enabled or masked. Edge events are captured into a pending bit that stays set until software clears it. Level sources hold no state: their status shows the qualified input as it is now.

Every input passes through a two-stage synchronizer before it is qualified. A bank's request line is the registered OR of the enabled status bits. Dual-edge detection is not offered, so a source watches exactly one direction. Any write that changes a source's mode or polarity drops that source's pending bit. This prevents a stale event from surviving a change of configuration.

Top module: `irqc_top`

## Requirements
- R1: After reset, the enable, mode and polarity registers of every bank read 0 and every `irq_o` bit is low. With all inputs low, each status register reads all ones, because every source starts level sensitive and active low.
- R2: The word address is {bank, select[2:0]}. Select 0 is enable, 1 is mode (1 = edge, 0 = level), 2 is polarity (1 = high/rising, 0 = low/falling), 3 is clear and reads 0, and 4 is status, which is read only: writes to it have no effect. Enable, mode and polarity read back what was written. Reads of an absent bank return 0.
- R3: In level mode a status bit equals the synchronized input when polarity is 1 and its inverse when polarity is 0. Nothing is stored, so status drops as soon as the input goes inactive.
- R4: In edge mode a rising edge (polarity 1) or a falling edge (polarity 0) sets the pending bit, and the bit stays set after the input returns. An edge in the other direction sets nothing.
- R5: Writing 1 to a clear bit removes that source's pending state. Writing 0 leaves it unchanged.
- R6: If an edge is detected in the same cycle as a clear write to that bit, the pending bit remains set.
- R7: A mode or polarity write that changes a bit clears that bit's pending state. A write that leaves the bit's value the same does not clear it.
- R8: `irq_o[b]` is the registered OR over bank b of status AND enable. A masked source never raises it.
- R9: Banks are independent. A write to one bank does not alter another bank's registers, and a source raises only its own bank's line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_BANKS*SRC_W | External interrupt lines, bank b at bits [b*SRC_W +: SRC_W] |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | BANK_W+3 | Word address {bank, select} |
| bus_wdata_i | input | SRC_W | Write data |
| bus_rdata_o | output | SRC_W | Read data for the addressed register, combinational |
| irq_o | output | NUM_BANKS | One interrupt request per bank |

## Verification
The hardest case to reach is an edge detected in exactly the cycle in which a clear write hits the same bit. The clear must arrive at the third clock edge after the input changes: two synchronizer stages and then the detection compare. The bench changes the input on a falling clock edge. It lets two further falling edges pass and then drives the clear write, so that the write lands on the edge where the pending bit is captured. It then checks that the bit survived. A second clear one cycle later shows that the same write does remove the bit when no edge coincides with it.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    SEL_EN   = 3'd0,
    SEL_MODE = 3'd1,
    SEL_POL  = 3'd2,
    SEL_CLR  = 3'd3,
    SEL_STAT = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         wr_i,
  input  reg_sel_e     sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_o
);
  logic [W-1:0] en_q, mode_q, pol_q, pend_q, prev_q, sync_w;
  logic [W-1:0] level_act, edge_det, clr_mask, cfg_chg, status, pend_d;
  logic         irq_q;

  irqc_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (sync_w)
  );

  assign level_act = ~(sync_w ^ pol_q);
  assign edge_det  = mode_q & ((pol_q & sync_w & ~prev_q) | (~pol_q & ~sync_w & prev_q));
  assign clr_mask  = (wr_i && sel_i == SEL_CLR) ? wdata_i : '0;
  assign cfg_chg   = ((wr_i && sel_i == SEL_MODE) ? (wdata_i ^ mode_q) : '0)
                   | ((wr_i && sel_i == SEL_POL)  ? (wdata_i ^ pol_q)  : '0);
  // new edge beats clear; config change beats everything
  assign pend_d    = (edge_det | (pend_q & ~clr_mask)) & ~cfg_chg;
  assign status    = (mode_q & pend_q) | (~mode_q & level_act);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      pend_q <= '0;
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_i && sel_i == SEL_EN)   en_q   <= wdata_i;
      if (wr_i && sel_i == SEL_MODE) mode_q <= wdata_i;
      if (wr_i && sel_i == SEL_POL)  pol_q  <= wdata_i;
      pend_q <= pend_d;
      prev_q <= sync_w;
      irq_q  <= |(status & en_q);
    end
  end

  always_comb begin
    case (sel_i)
      SEL_EN:   rdata_o = en_q;
      SEL_MODE: rdata_o = mode_q;
      SEL_POL:  rdata_o = pol_q;
      SEL_STAT: rdata_o = status;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  assert_level_no_store_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~mode_q) == '0);
  assert_clear_takes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q & $past(clr_mask & ~edge_det)) == '0);
  assert_edge_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($past(edge_det & ~cfg_chg) & ~pend_q) == '0);
  assert_cfg_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q & $past(cfg_chg)) == '0);
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |=> !irq_o);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_BANKS = 5,
  parameter int SRC_W     = 32,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W   = BANK_W + 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_BANKS*SRC_W-1:0] src_i,
  input  logic                       bus_we_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [SRC_W-1:0]           bus_wdata_i,
  output logic [SRC_W-1:0]           bus_rdata_o,
  output logic [NUM_BANKS-1:0]       irq_o
);
  logic [BANK_W-1:0] bank_idx;
  reg_sel_e          sel;
  logic [SRC_W-1:0]  bank_rdata [NUM_BANKS];

  assign bank_idx = bus_addr_i[ADDR_W-1:3];
  assign sel      = reg_sel_e'(bus_addr_i[2:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqc_bank #(.W(SRC_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[b*SRC_W +: SRC_W]),
      .wr_i   (bus_we_i && bank_idx == BANK_W'(b)),
      .sel_i  (sel),
      .wdata_i(bus_wdata_i),
      .rdata_o(bank_rdata[b]),
      .irq_o  (irq_o[b])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bank_idx == BANK_W'(b)) bus_rdata_o = bank_rdata[b];
  end
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int NB = 5;
  localparam int W  = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NB*W-1:0] src = '0;
  logic          we = 0;
  logic [5:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic [NB-1:0] irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irqc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [5:0] ad(int bank, int sel);
    return {3'(bank), 3'(sel)};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; src = '0; we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(int bank, int sel, logic [W-1:0] d);
    @(negedge clk); addr = ad(bank, sel); wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(string req, int bank, int sel, logic [W-1:0] mask, logic [W-1:0] exp);
    @(negedge clk); addr = ad(bank, sel); #0.5;
    chk(req, rdata & mask, exp & mask);
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask

  task automatic t_reset();
    do_reset();
    for (int b = 0; b < NB; b++) begin
      rd("R1", b, 0, '1, '0);
      rd("R1", b, 1, '1, '0);
      rd("R1", b, 2, '1, '0);
      rd("R1", b, 4, '1, '1);
    end
    chk("R1", W'(irq), '0);
  endtask

  task automatic t_addr();
    do_reset();
    wr(0, 0, 32'hA5A5_0F0F);
    wr(1, 1, 32'h1234_5678);
    wr(2, 2, 32'hDEAD_BEEF);
    rd("R2", 0, 0, '1, 32'hA5A5_0F0F);
    rd("R2", 1, 1, '1, 32'h1234_5678);
    rd("R2", 2, 2, '1, 32'hDEAD_BEEF);
    rd("R2", 0, 3, '1, '0);
    wr(3, 4, '0);
    rd("R2", 3, 4, '1, '1);
    rd("R2", 6, 0, '1, '0);
    rd("R9", 1, 0, '1, '0);
    rd("R9", 0, 1, '1, '0);
    rd("R9", 3, 2, '1, '0);
  endtask

  task automatic t_level();
    do_reset();
    wr(0, 2, 32'h8);
    src[3] = 1; settle();
    rd("R3", 0, 4, 32'h8, 32'h8);
    src[3] = 0; settle();
    rd("R3", 0, 4, 32'h8, 32'h0);
    wr(0, 2, 32'h0); settle();
    rd("R3", 0, 4, 32'h8, 32'h8);
  endtask

  task automatic t_edge();
    do_reset();
    wr(1, 1, 32'h20); wr(1, 2, 32'h20);
    src[W+5] = 1; settle();
    rd("R4", 1, 4, 32'h20, 32'h20);
    src[W+5] = 0; settle();
    rd("R4", 1, 4, 32'h20, 32'h20);
    wr(1, 2, 32'h0);
    rd("R7", 1, 4, 32'h20, 32'h0);
    src[W+5] = 1; settle();
    rd("R4", 1, 4, 32'h20, 32'h0);
    src[W+5] = 0; settle();
    rd("R4", 1, 4, 32'h20, 32'h20);
  endtask

  task automatic t_clear();
    do_reset();
    wr(1, 1, 32'hA0); wr(1, 2, 32'hA0);
    src[W+5] = 1; src[W+7] = 1; settle();
    wr(1, 3, 32'h0);
    rd("R5", 1, 4, 32'hA0, 32'hA0);
    wr(1, 3, 32'h20);
    rd("R5", 1, 4, 32'hA0, 32'h80);
  endtask

  task automatic t_same_cycle();
    do_reset();
    wr(0, 1, 32'h2); wr(0, 2, 32'h2);
    @(negedge clk); src[1] = 1;
    @(negedge clk);
    @(negedge clk); addr = ad(0, 3); wdata = 32'h2; we = 1;
    @(negedge clk); we = 0;
    rd("R6", 0, 4, 32'h2, 32'h2);
    wr(0, 3, 32'h2);
    rd("R5", 0, 4, 32'h2, 32'h0);
  endtask

  task automatic t_cfg();
    do_reset();
    wr(2, 1, 32'h1); wr(2, 2, 32'h1);
    src[2*W] = 1; settle();
    rd("R7", 2, 4, 32'h1, 32'h1);
    wr(2, 2, 32'h1);
    rd("R7", 2, 4, 32'h1, 32'h1);
    wr(2, 2, 32'h0);
    rd("R7", 2, 4, 32'h1, 32'h0);
    wr(2, 2, 32'h1);
    src[2*W] = 0; settle(); src[2*W] = 1; settle();
    rd("R7", 2, 4, 32'h1, 32'h1);
    wr(2, 1, 32'h0);
    wr(2, 1, 32'h1);
    rd("R7", 2, 4, 32'h1, 32'h0);
  endtask

  task automatic t_irq();
    do_reset();
    wr(2, 2, 32'h1);
    src[2*W] = 1; settle();
    chk("R8", W'(irq), '0);
    wr(2, 0, 32'h1); settle();
    chk("R8", W'(irq), 32'h4);
    src[2*W] = 0; settle();
    chk("R8", W'(irq), '0);
    wr(2, 1, 32'h2); wr(2, 2, 32'h3);
    src[2*W+1] = 1; settle();
    chk("R8", W'(irq), '0);
    wr(2, 0, 32'h2); settle();
    chk("R8", W'(irq), 32'h4);
    wr(2, 3, 32'h2); settle();
    chk("R8", W'(irq), '0);
  endtask

  task automatic t_banks();
    do_reset();
    wr(4, 2, 32'h8000_0000); wr(4, 0, 32'h8000_0000);
    wr(3, 2, 32'h8000_0000); wr(3, 0, 32'h8000_0000);
    src[5*W-1] = 1; settle();
    chk("R9", W'(irq), 32'h10);
    src[4*W-1] = 1; src[5*W-1] = 0; settle();
    chk("R9", W'(irq), 32'h08);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_addr();
    t_level();
    t_edge();
    t_clear();
    t_same_cycle();
    t_cfg();
    t_irq();
    t_banks();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule